// File: doc/BRIEF.md
# Three-wire serial EEPROM slave model

This block is a synthesizable model of a small serial EEPROM that holds 128 words of 16 bits. It is attached to a host over a three-wire serial link: a select line, a serial clock and a data input. A fourth pin carries read data and write status back to the host. The select and serial clock are oversampled by the system clock. Every function of the block acts on a rising edge of the serial clock seen while select is high.

A transaction begins with a start bit. An opcode and an address field follow it, and data follows for the commands that carry any. The block offers single-word read with automatic address increment, single-word write, fill-all, single-word erase and full erase, plus a pair of commands that open and close a software write guard. A parameterised cycle counter stands in for the internal programming time. While it runs, the output pin reports busy or ready to the host.

The storage is a plain register array. The output pin is modelled as a data line plus an output-enable line, so a chip-level pad can build the tri-state driver.

Top module: `mwire_eeprom`

## Requirements
- R1: After reset every word reads back as 0xFFFF and the write guard is closed.
- R2: Data-in values of 0 sampled before the first 1 after select rises are ignored. That first 1 is the start bit.
- R3: The start bit is followed by a 2-bit opcode and then an 8-bit address field, whose low 7 bits are the word address. Opcode 10 is READ. On the rising edge that samples the last address bit, data out drives a dummy 0. Each following rising edge then drives one data bit, bit 15 first.
- R4: While the serial clock keeps running in a READ, the words at the following addresses come out back to back with no further dummy bit. The address wraps from 127 to 0.
- R5: Opcode 00 with address bits 7:6 = 11 opens the write guard, and with 00 it closes it. While the guard is closed, WRITE, fill-all, ERASE and full erase change no word and start no busy period.
- R6: Opcode 01 (WRITE) takes 16 data bits, bit 15 first, after the address field. The addressed word is replaced by them.
- R7: Opcode 00 with address bits 7:6 = 01 (fill-all) takes 16 data bits and writes them to every word.
- R8: Opcode 11 (ERASE) sets the addressed word to 0xFFFF. Opcode 00 with address bits 7:6 = 10 (full erase) sets every word to 0xFFFF.
- R9: A write or erase that is allowed starts a busy period of WR_CYCLES clocks. After the command, whenever select is high, data out drives 0 while busy and 1 once ready.
- R10: A start bit sent during the busy period is ignored, so the command that follows it has no effect.
- R11: Data out is not driven (output enable 0) whenever select is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the serial pins |
| rst_n | input | 1 | Active-low synchronous reset |
| cs | input | 1 | Select, active high |
| sk | input | 1 | Serial clock; rising edges shift bits |
| di | input | 1 | Serial data in |
| do_o | output | 1 | Serial data out: read data or ready status |
| do_oe | output | 1 | Output enable for the data-out pad |

## Verification
The hardest case to reach is a command that arrives during the busy period. From the ports it looks like a normal transaction, and it can only be told apart by its missing effect. The stimulus launches a write, keeps select high and clocks a complete second write to a word written earlier before the timer expires. It then waits for ready and reads that word back to show that the old value survived. The wrap of a sequential read from the last word to word 0 is also reached on purpose, by writing word 127 and reading two words from there. Random commands, with the write guard toggled at random, follow these directed cases.

// File: rtl/mwire_pkg.sv
package mwire_pkg;
    typedef enum logic [2:0] {
        ST_HUNT,
        ST_CMD,
        ST_DATA,
        ST_READ,
        ST_WAIT
    } mw_state_e;

    typedef enum logic [1:0] {
        OP_EXT   = 2'b00,
        OP_WRITE = 2'b01,
        OP_READ  = 2'b10,
        OP_ERASE = 2'b11
    } mw_op_e;

    typedef enum logic [1:0] {
        SUB_GUARD_OFF = 2'b00,
        SUB_FILL      = 2'b01,
        SUB_WIPE      = 2'b10,
        SUB_GUARD_ON  = 2'b11
    } mw_sub_e;
endpackage

// File: rtl/mwire_sk_edge.sv
module mwire_sk_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic sk,
    output logic sk_rise
);
    logic sk_d, sk_q;

    always_comb sk_d = sk;

    always_ff @(posedge clk) begin
        if (!rst_n) sk_q <= 1'b0;
        else        sk_q <= sk_d;
    end

    assign sk_rise = sk & ~sk_q;
endmodule

// File: rtl/mwire_wtimer.sv
module mwire_wtimer #(
    parameter int WR_CYCLES = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy
);
    localparam int TW = $clog2(WR_CYCLES + 1);

    logic [TW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (start)             cnt_d = TW'(WR_CYCLES);
        else if (cnt_q != '0)  cnt_d = cnt_q - TW'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign busy = (cnt_q != '0);
endmodule

// File: rtl/mwire_array.sv
module mwire_array #(
    parameter int AW = 7,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we_one,
    input  logic          we_all,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem_q [DEPTH];

    for (genvar w = 0; w < DEPTH; w++) begin : g_word
        logic [DW-1:0] word_d;
        always_comb begin
            word_d = mem_q[w];
            if (we_all || (we_one && waddr == AW'(w))) word_d = wdata;
        end
        always_ff @(posedge clk) begin
            if (!rst_n) mem_q[w] <= '1;
            else        mem_q[w] <= word_d;
        end
    end

    assign rdata = mem_q[raddr];
endmodule

// File: rtl/mwire_eeprom.sv
module mwire_eeprom
    import mwire_pkg::*;
#(
    parameter int AW        = 7,
    parameter int DW        = 16,
    parameter int WR_CYCLES = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs,
    input  logic sk,
    input  logic di,
    output logic do_o,
    output logic do_oe
);
    // opcode (2) + address field (AW+1)
    localparam int CMDW = AW + 3;
    localparam int CW   = $clog2((CMDW > DW) ? CMDW : DW);

    typedef struct packed {
        mw_state_e      st;
        logic [CW-1:0]  cnt;
        logic [CMDW-2:0] cmd;
        logic [DW-1:0]  sh;
        logic [AW-1:0]  addr;
        logic           fill;
        logic           wen;
        logic           stat;
        logic           dout;
    } regs_t;

    regs_t r_d, r_q;

    logic          sk_rise, busy, wr_start, we_one, we_all;
    logic [AW-1:0] waddr, raddr;
    logic [DW-1:0] wdata, rdata;
    logic [CMDW-1:0] full;
    logic [AW:0]   afield;
    mw_op_e        op;
    mw_sub_e       sub;

    mwire_sk_edge u_edge (.clk(clk), .rst_n(rst_n), .sk(sk), .sk_rise(sk_rise));

    mwire_wtimer #(.WR_CYCLES(WR_CYCLES)) u_timer (
        .clk(clk), .rst_n(rst_n), .start(wr_start), .busy(busy)
    );

    mwire_array #(.AW(AW), .DW(DW)) u_array (
        .clk(clk), .rst_n(rst_n), .we_one(we_one), .we_all(we_all),
        .waddr(waddr), .wdata(wdata), .raddr(raddr), .rdata(rdata)
    );

    always_comb begin
        full   = {r_q.cmd, di};
        op     = mw_op_e'(full[CMDW-1 -: 2]);
        afield = full[AW:0];
        sub    = mw_sub_e'(afield[AW -: 2]);
        waddr  = (r_q.st == ST_CMD) ? afield[AW-1:0] : r_q.addr;
        raddr  = (r_q.st == ST_READ) ? r_q.addr + AW'(1) : afield[AW-1:0];
    end

    always_comb begin
        r_d      = r_q;
        we_one   = 1'b0;
        we_all   = 1'b0;
        wdata    = '1;
        wr_start = 1'b0;
        if (!cs) begin
            r_d.st  = ST_HUNT;
            r_d.cnt = '0;
        end else if (sk_rise) begin
            case (r_q.st)
                ST_HUNT: begin
                    if (di && !busy) begin
                        r_d.st   = ST_CMD;
                        r_d.cnt  = '0;
                        r_d.stat = 1'b0;
                    end
                end
                ST_CMD: begin
                    r_d.cmd = full[CMDW-2:0];
                    r_d.cnt = r_q.cnt + CW'(1);
                    if (r_q.cnt == CW'(CMDW - 1)) begin
                        r_d.cnt  = '0;
                        r_d.addr = afield[AW-1:0];
                        r_d.st   = ST_WAIT;
                        case (op)
                            OP_READ: begin
                                r_d.st   = ST_READ;
                                r_d.sh   = rdata;
                                r_d.dout = 1'b0;
                            end
                            OP_WRITE: begin
                                r_d.st   = ST_DATA;
                                r_d.fill = 1'b0;
                            end
                            OP_ERASE: begin
                                if (r_q.wen) begin
                                    we_one   = 1'b1;
                                    wr_start = 1'b1;
                                    r_d.stat = 1'b1;
                                end
                            end
                            default: begin
                                case (sub)
                                    SUB_GUARD_ON:  r_d.wen = 1'b1;
                                    SUB_GUARD_OFF: r_d.wen = 1'b0;
                                    SUB_FILL: begin
                                        r_d.st   = ST_DATA;
                                        r_d.fill = 1'b1;
                                    end
                                    default: begin
                                        if (r_q.wen) begin
                                            we_all   = 1'b1;
                                            wr_start = 1'b1;
                                            r_d.stat = 1'b1;
                                        end
                                    end
                                endcase
                            end
                        endcase
                    end
                end
                ST_DATA: begin
                    r_d.sh  = {r_q.sh[DW-2:0], di};
                    r_d.cnt = r_q.cnt + CW'(1);
                    if (r_q.cnt == CW'(DW - 1)) begin
                        r_d.cnt = '0;
                        r_d.st  = ST_WAIT;
                        if (r_q.wen) begin
                            we_one   = ~r_q.fill;
                            we_all   = r_q.fill;
                            wdata    = {r_q.sh[DW-2:0], di};
                            wr_start = 1'b1;
                            r_d.stat = 1'b1;
                        end
                    end
                end
                ST_READ: begin
                    r_d.dout = r_q.sh[DW-1];
                    if (r_q.cnt == CW'(DW - 1)) begin
                        r_d.cnt  = '0;
                        r_d.addr = r_q.addr + AW'(1);
                        r_d.sh   = rdata;
                    end else begin
                        r_d.cnt = r_q.cnt + CW'(1);
                        r_d.sh  = {r_q.sh[DW-2:0], 1'b0};
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q      <= '0;
            r_q.st   <= ST_HUNT;
        end else begin
            r_q <= r_d;
        end
    end

    assign do_oe = cs && ((r_q.st == ST_READ) || r_q.stat);
    assign do_o  = (r_q.st == ST_READ) ? r_q.dout : ~busy;
endmodule

// File: rtl/mwire_eeprom_chk.sv
module mwire_eeprom_chk (
    input logic clk,
    input logic rst_n,
    input logic cs,
    input logic do_o,
    input logic do_oe,
    input logic busy,
    input logic wr_start,
    input logic we_one,
    input logic we_all,
    input logic wen,
    input logic rd_active
);
    assert_hiz_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !cs |-> !do_oe);

    assert_no_ready_while_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !(do_oe && do_o));

    assert_guard_blocks_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (we_one || we_all) |-> wen);

    assert_busy_ignores_R10: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !wr_start);

    assert_dummy_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(rd_active) && cs) |-> (do_oe && !do_o));

    assert_one_strobe_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(we_one && we_all));
endmodule

bind mwire_eeprom mwire_eeprom_chk u_chk (
    .clk(clk), .rst_n(rst_n), .cs(cs), .do_o(do_o), .do_oe(do_oe),
    .busy(busy), .wr_start(wr_start), .we_one(we_one), .we_all(we_all),
    .wen(r_q.wen), .rd_active(r_q.st == mwire_pkg::ST_READ)
);

// File: tb/mwire_eeprom_tb.sv
module mwire_eeprom_tb;
    localparam int WRC = 200;
    localparam int H   = 2;

    logic clk = 1'b0, rst_n = 1'b0, cs = 1'b0, sk = 1'b0, di = 1'b0;
    logic do_o, do_oe;
    logic last_o, last_oe;
    int   nchk = 0, nerr = 0;
    bit   done = 0;
    logic [15:0] mem_m [128];
    logic wen_m = 1'b0;

    always #2 clk = ~clk;

    mwire_eeprom #(.WR_CYCLES(WRC)) u_dut (
        .clk(clk), .rst_n(rst_n), .cs(cs), .sk(sk), .di(di),
        .do_o(do_o), .do_oe(do_oe)
    );

    function automatic logic [6:0] next_addr(logic [6:0] a, int k);
        return 7'((int'(a) + k) % 128);
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic sk_bit(input logic b);
        di = b;
        repeat (H) @(negedge clk);
        sk = 1'b1;
        repeat (H) @(negedge clk);
        last_o  = do_o;
        last_oe = do_oe;
        sk = 1'b0;
    endtask

    task automatic send_cmd(input logic [1:0] op, input logic [7:0] af, input int zeros);
        cs = 1'b1; di = 1'b0;
        repeat (2) @(negedge clk);
        for (int i = 0; i < zeros; i++) sk_bit(1'b0);
        sk_bit(1'b1);
        for (int i = 1; i >= 0; i--) sk_bit(op[i]);
        for (int i = 7; i >= 0; i--) sk_bit(af[i]);
    endtask

    task automatic send_data(input logic [15:0] d);
        for (int i = 15; i >= 0; i--) sk_bit(d[i]);
    endtask

    task automatic end_cs();
        di = 1'b0;
        @(negedge clk);
        cs = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic wait_ready(string req);
        int n;
        cs = 1'b1;
        @(negedge clk);
        n = 0;
        while (!(do_oe && do_o) && n < 3 * WRC) begin
            @(negedge clk);
            n++;
        end
        check(req, {31'b0, do_oe && do_o}, 32'd1);
        end_cs();
    endtask

    task automatic do_read(input logic [6:0] a, input int n, string req);
        logic [15:0] w;
        send_cmd(2'b10, {1'b0, a}, 0);
        for (int k = 0; k < n; k++) begin
            for (int i = 15; i >= 0; i--) begin
                sk_bit(1'b0);
                w[i] = last_o;
            end
            check(req, {16'b0, w}, {16'b0, mem_m[next_addr(a, k)]});
        end
        end_cs();
    endtask

    task automatic do_write(input logic [6:0] a, input logic [15:0] d);
        send_cmd(2'b01, {1'b0, a}, 0);
        send_data(d);
        end_cs();
        if (wen_m) begin
            mem_m[a] = d;
            wait_ready("R9 ready after write");
        end
    endtask

    task automatic do_ext(input logic [1:0] sub, input logic [15:0] d);
        send_cmd(2'b00, {sub, 6'h2a}, 0);
        if (sub == 2'b01) send_data(d);
        end_cs();
        case (sub)
            2'b11: wen_m = 1'b1;
            2'b00: wen_m = 1'b0;
            default: if (wen_m) begin
                for (int i = 0; i < 128; i++) mem_m[i] = (sub == 2'b01) ? d : 16'hFFFF;
                wait_ready("R9 ready after bulk");
            end
        endcase
    endtask

    task automatic do_erase(input logic [6:0] a);
        send_cmd(2'b11, {1'b0, a}, 0);
        end_cs();
        if (wen_m) begin
            mem_m[a] = 16'hFFFF;
            wait_ready("R9 ready after erase");
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            nerr++; nchk++;
            $display("FAIL watchdog expired act=1 exp=0");
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end

    initial begin
        logic [15:0] w;
        void'($urandom(32'd4711));
        for (int i = 0; i < 128; i++) mem_m[i] = 16'hFFFF;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R11 / R1: pad undriven while cs low after reset
        check("R11 oe low with cs low", {31'b0, do_oe}, 32'd0);

        // R3 / R1: dummy bit, then reset contents
        send_cmd(2'b10, 8'h05, 0);
        check("R3 dummy bit driven", {31'b0, last_oe}, 32'd1);
        check("R3 dummy bit value", {31'b0, last_o}, 32'd0);
        for (int i = 15; i >= 0; i--) begin sk_bit(1'b0); w[i] = last_o; end
        check("R1 reset word is FFFF", {16'b0, w}, 32'h0000FFFF);
        end_cs();
        check("R11 oe low after read", {31'b0, do_oe}, 32'd0);

        // R5: guard closed at reset
        do_write(7'd3, 16'h1234);
        cs = 1'b1; repeat (3) @(negedge clk);
        check("R5 no status when guarded", {31'b0, do_oe}, 32'd0);
        end_cs();
        do_read(7'd3, 1, "R5 guarded write no change");

        // R2 + R6 + R9: open guard, write with leading zeros, time busy
        do_ext(2'b11, 16'h0);
        send_cmd(2'b01, 8'h03, 3);
        send_data(16'hA5C3);
        end_cs();
        cs = 1'b1; @(negedge clk);
        check("R9 status driven", {31'b0, do_oe}, 32'd1);
        check("R9 busy reads 0", {31'b0, do_o}, 32'd0);
        repeat (WRC - 20) @(negedge clk);
        check("R9 still busy near end", {31'b0, do_o}, 32'd0);
        repeat (30) @(negedge clk);
        check("R9 ready after WR_CYCLES", {31'b0, do_o}, 32'd1);
        end_cs();
        mem_m[3] = 16'hA5C3;
        do_read(7'd3, 1, "R6 R2 written word");

        // R10: command during busy ignored
        send_cmd(2'b01, 8'h04, 0);
        send_data(16'h1111);
        end_cs();
        mem_m[4] = 16'h1111;
        send_cmd(2'b01, 8'h03, 0);
        send_data(16'h0000);
        check("R10 status kept during ignored cmd", {30'b0, last_oe, last_o}, 32'd2);
        end_cs();
        wait_ready("R10 ready");
        do_read(7'd3, 1, "R10 busy write ignored");
        do_read(7'd4, 1, "R6 first write landed");

        // R4: wrap
        do_write(7'd127, 16'hBEEF);
        do_read(7'd127, 2, "R4 wrap 127 to 0");
        do_read(7'd2, 3, "R4 sequential read");

        // R8 erase, R7 fill, R8 wipe, R5 guard close
        do_erase(7'd3);
        do_read(7'd3, 1, "R8 erase word");
        do_ext(2'b01, 16'h5A5A);
        do_read(7'd0, 2, "R7 fill all");
        do_read(7'd90, 1, "R7 fill all");
        do_ext(2'b10, 16'h0);
        do_read(7'd64, 2, "R8 wipe all");
        do_ext(2'b00, 16'h0);
        do_write(7'd10, 16'h7777);
        do_erase(7'd10);
        do_read(7'd10, 1, "R5 guard closed again");

        // random mix
        for (int it = 0; it < 40; it++) begin
            int kind;
            logic [6:0] a;
            kind = int'($urandom % 6);
            a = 7'($urandom);
            case (kind)
                0, 1: do_write(a, 16'($urandom));
                2: do_erase(a);
                3: do_ext(($urandom % 4 == 0) ? 2'b00 : 2'b11, 16'h0);
                4: do_ext(2'b01, 16'($urandom));
                default: do_read(a, 1 + int'($urandom % 2), "R6 R4 random read");
            endcase
        end
        for (int k = 0; k < 8; k++) do_read(7'(k * 16 + 5), 1, "R6 final sweep");

        done = 1;
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule